// File: doc/BRIEF.md
# Shared-Multiplier Clarke/Park Frame Transform

This block turns one sample of a three-wire, three-phase system into the rotating direct/quadrature frame, in fixed point. It is given two measured phases of the voltage set and two measured phases of the load-current set. It rebuilds the missing phase of each set from the other two. It then applies the stationary two-axis (Clarke) step and the rotation (Park) step. The rotation uses a sine/cosine pair from an external phase tracker.

One registered multiplier and one accumulator serve all ten products of a sample. A step counter steers operand multiplexers and routes each result to its own register. The block therefore finishes in a fixed number of clock cycles. This is far inside a 50 kHz update period at any practical clock.

A controller raises `start` once per sample period. The block captures every input at the accepting edge. A one-cycle `done` pulse marks the point where all four outputs hold the new sample's values.

Top module: `clarke_park_tdm`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears all four outputs to 0 and drives `done` low after that edge.
- R2: The block rebuilds the third phase as c = -(a+b). It takes alpha = a and beta = floor((b - c) * 18919 / 2^15), where 18919 is 1/sqrt(3) in signed Q1.15.
- R3: With sine s and cosine k as signed Q1.15, the block computes d = floor((alpha*k + beta*s) / 2^15) and q = floor((beta*k - alpha*s) / 2^15). Both products of each sum are kept at full precision before the single floor shift.
- R4: The voltage pair (`va_in`,`vb_in`) yields `vd_out`/`vq_out`. The current pair (`ia_in`,`ib_in`) yields `id_out`/`iq_out`. Both sets use the same sine/cosine pair.
- R5: The block takes all six data inputs at the edge where it accepts `start`. Input changes after that edge have no effect on the current results.
- R6: `done` is high for exactly one cycle. It rises after the 11th rising edge that follows the accepting edge.
- R7: A `start` raised while a transform is running is ignored. No extra `done` pulse follows, and the outputs keep the first transform's results.
- R8: While the block is idle, all four outputs hold their values.
- R9: A `start` sampled in the cycle where `done` is high is accepted. It begins a new transform at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a transform on the current inputs (taken when idle) |
| va_in | input | 12 | Voltage phase a, signed |
| vb_in | input | 12 | Voltage phase b, signed |
| ia_in | input | 12 | Load current phase a, signed |
| ib_in | input | 12 | Load current phase b, signed |
| sin_in | input | 16 | Sine of the tracked angle, signed Q1.15 |
| cos_in | input | 16 | Cosine of the tracked angle, signed Q1.15 |
| vd_out | output | 18 | Voltage direct component, signed |
| vq_out | output | 18 | Voltage quadrature component, signed |
| id_out | output | 18 | Current direct component, signed |
| iq_out | output | 18 | Current quadrature component, signed |
| done | output | 1 | One-cycle pulse when all four outputs are updated |

## Verification
An operand-select or routing fault in the shared schedule shows in the outputs of the very transform it hits. Such a fault swaps angles, mixes sets or uses a stale beta or accumulator value, and the output no longer matches the closed-form d/q values. Angles with sine and cosine of differing sign and magnitude expose these faults. So do samples with a ≠ b, and with voltage and current sets that differ. A counter or control fault moves the done pulse away from cycle 11, stretches it, or lets a mid-run start restart the schedule. Each case is visible within one transform.

// File: rtl/clarke_park_pkg.sv
// Shared definitions for the shared-multiplier Clarke/Park transform.
// Assumes two data sets (voltage, current) of a fixed number of steps each.
package clarke_park_pkg;

    // Writeback action performed on the registered product
    typedef enum logic [1:0] {
        WB_BETA  = 2'd0,   // store scaled product as beta
        WB_ACC   = 2'd1,   // load accumulator with product
        WB_OUT_D = 2'd2,   // acc + product -> d output of current set
        WB_OUT_Q = 2'd3    // acc + product -> q output of current set
    } wb_op_e;

    localparam int STEPS_PER_SET = 5;
    localparam int NUM_SETS      = 2;
    localparam int NUM_STEPS     = STEPS_PER_SET * NUM_SETS;

endpackage

// File: rtl/clarke_park_seq.sv
// Step sequencer: accepts start when idle, walks the operation schedule,
// allows one extra cycle for the writeback stage, then pulses done.
// Assumes a one-stage multiplier register followed by one writeback stage.
module clarke_park_seq #(
    parameter int NSTEP = 10,
    localparam int CW   = $clog2(NSTEP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          accept,
    output logic          busy,
    output logic          issue_valid,
    output logic [CW-1:0] step,
    output logic          done
);

    localparam logic [CW-1:0] LAST = CW'(NSTEP);

    // Accept a new run only when idle
    assign accept      = start && !busy;
    // An operation enters the multiplier while the step is in range
    assign issue_valid = busy && (step < LAST);

    // Run control: advance the step, close the run after the drain cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy <= 1'b1;
                step <= '0;
            end else if (busy) begin
                if (step == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step <= step + 1'b1;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R6
    AST_RUN_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && step != LAST) |=> (busy && step == $past(step) + 1'b1)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !done);                                                // R1

endmodule

// File: rtl/clarke_park_opmux.sv
// Operand selector: from the step number picks the data set, the operand
// pair for the shared multiplier and the writeback action.
// Assumes steps 0..4 serve the voltage set and 5..9 the current set.
module clarke_park_opmux
    import clarke_park_pkg::*;
#(
    parameter int SW      = 12,
    parameter int TW      = 16,
    parameter int COEF_K  = 18919,
    parameter int CW      = 4,
    localparam int OPA_W  = SW + 3
) (
    input  logic                    issue_valid,
    input  logic [CW-1:0]           step,
    input  logic signed [SW-1:0]    v_a,
    input  logic signed [SW-1:0]    v_b,
    input  logic signed [SW-1:0]    i_a,
    input  logic signed [SW-1:0]    i_b,
    input  logic signed [TW-1:0]    sin_v,
    input  logic signed [TW-1:0]    cos_v,
    input  logic signed [OPA_W-1:0] beta,
    output logic signed [OPA_W-1:0] opa,
    output logic signed [TW-1:0]    opb,
    output wb_op_e                  wb_op,
    output logic                    set_sel
);

    localparam logic [CW-1:0] SPS = CW'(STEPS_PER_SET);

    logic [CW-1:0]           lstep;
    logic signed [OPA_W-1:0] alpha_x;
    logic signed [OPA_W-1:0] phc_x;
    logic signed [OPA_W-1:0] diff_x;

    // Pick the data set and the step within it
    always_comb begin
        set_sel = (step >= SPS);
        lstep   = set_sel ? (step - SPS) : step;
    end

    // Rebuild the third phase and form the Clarke difference term
    always_comb begin
        alpha_x = set_sel ? OPA_W'(i_a) : OPA_W'(v_a);
        diff_x  = set_sel ? OPA_W'(i_b) : OPA_W'(v_b);
        phc_x   = -(alpha_x + diff_x);
        diff_x  = diff_x - phc_x;
    end

    // Operand pair and writeback action for each step of the schedule
    always_comb begin
        opa   = '0;
        opb   = '0;
        wb_op = WB_ACC;
        if (issue_valid) begin
            unique case (lstep)
                CW'(0): begin opa = diff_x;   opb = TW'(COEF_K); wb_op = WB_BETA;  end
                CW'(1): begin opa = alpha_x;  opb = cos_v;       wb_op = WB_ACC;   end
                CW'(2): begin opa = beta;     opb = sin_v;       wb_op = WB_OUT_D; end
                CW'(3): begin opa = -alpha_x; opb = sin_v;       wb_op = WB_ACC;   end
                default: begin opa = beta;    opb = cos_v;       wb_op = WB_OUT_Q; end
            endcase
        end
    end

endmodule

// File: rtl/clarke_park_mac.sv
// Shared datapath: one registered multiplier, then a writeback stage that
// stores beta, loads the accumulator, or adds and routes a saturated,
// scaled sum to the d or q register of the selected set.
// Assumes the schedule never reads beta or acc in the cycle it is written.
module clarke_park_mac
    import clarke_park_pkg::*;
#(
    parameter int SW      = 12,
    parameter int TW      = 16,
    parameter int OW      = 18,
    localparam int OPA_W  = SW + 3,
    localparam int PROD_W = OPA_W + TW,
    localparam int ACC_W  = PROD_W + 1,
    localparam int FRAC   = TW - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    issue_valid,
    input  logic signed [OPA_W-1:0] opa,
    input  logic signed [TW-1:0]    opb,
    input  wb_op_e                  wb_op,
    input  logic                    set_sel,
    output logic signed [OPA_W-1:0] beta,
    output logic signed [OW-1:0]    d_out [NUM_SETS],
    output logic signed [OW-1:0]    q_out [NUM_SETS]
);

    localparam logic signed [ACC_W-1:0] OMAX = ACC_W'((64'sd1 <<< (OW - 1)) - 1);
    localparam logic signed [ACC_W-1:0] OMIN = -ACC_W'(64'sd1 <<< (OW - 1));

    logic signed [PROD_W-1:0] prod_q;
    logic                     vld_q;
    wb_op_e                   op_q;
    logic                     set_q;
    logic signed [PROD_W-1:0] acc_q;
    logic signed [ACC_W-1:0]  sum_s;
    logic signed [ACC_W-1:0]  sum_scaled;
    logic signed [PROD_W-1:0] prod_scaled;
    logic signed [OW-1:0]     sum_sat;

    // Multiplier stage: register product and the control that goes with it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            vld_q  <= 1'b0;
            op_q   <= WB_ACC;
            set_q  <= 1'b0;
        end else begin
            prod_q <= PROD_W'(opa) * PROD_W'(opb);
            vld_q  <= issue_valid;
            op_q   <= wb_op;
            set_q  <= set_sel;
        end
    end

    // Add to the accumulator, scale once and clamp to the output range
    always_comb begin
        sum_s       = ACC_W'(acc_q) + ACC_W'(prod_q);
        sum_scaled  = sum_s >>> FRAC;
        prod_scaled = prod_q >>> FRAC;
        if (sum_scaled > OMAX)      sum_sat = OMAX[OW-1:0];
        else if (sum_scaled < OMIN) sum_sat = OMIN[OW-1:0];
        else                        sum_sat = sum_scaled[OW-1:0];
    end

    // Writeback stage: beta and accumulator registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beta  <= '0;
            acc_q <= '0;
        end else if (vld_q) begin
            if (op_q == WB_BETA) beta  <= prod_scaled[OPA_W-1:0];
            if (op_q == WB_ACC)  acc_q <= prod_q;
        end
    end

    // Output demultiplexer: one d and one q register per data set
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                d_out[g] <= '0;
                q_out[g] <= '0;
            end else if (vld_q && set_q == 1'(g)) begin
                if (op_q == WB_OUT_D) d_out[g] <= sum_sat;
                if (op_q == WB_OUT_Q) q_out[g] <= sum_sat;
            end
        end
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |=> ($stable(beta) && $stable(acc_q))); // R3

endmodule

// File: rtl/clarke_park_tdm.sv
// Top: captures the six inputs on an accepted start, then runs the
// ten-step shared-multiplier schedule for the voltage set and then the
// current set. Assumes a three-wire system (phase c = -(a+b)).
module clarke_park_tdm
    import clarke_park_pkg::*;
#(
    parameter int SW     = 12,
    parameter int TW     = 16,
    parameter int OW     = 18,
    parameter int COEF_K = 18919,
    localparam int CW    = $clog2(NUM_STEPS + 1),
    localparam int OPA_W = SW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic signed [SW-1:0] va_in,
    input  logic signed [SW-1:0] vb_in,
    input  logic signed [SW-1:0] ia_in,
    input  logic signed [SW-1:0] ib_in,
    input  logic signed [TW-1:0] sin_in,
    input  logic signed [TW-1:0] cos_in,
    output logic signed [OW-1:0] vd_out,
    output logic signed [OW-1:0] vq_out,
    output logic signed [OW-1:0] id_out,
    output logic signed [OW-1:0] iq_out,
    output logic                 done
);

    logic                    accept, busy, issue_valid, set_sel;
    logic [CW-1:0]           step;
    logic signed [SW-1:0]    va_r, vb_r, ia_r, ib_r;
    logic signed [TW-1:0]    sin_r, cos_r;
    logic signed [OPA_W-1:0] opa, beta;
    logic signed [TW-1:0]    opb;
    wb_op_e                  wb_op;
    logic signed [OW-1:0]    d_arr [NUM_SETS];
    logic signed [OW-1:0]    q_arr [NUM_SETS];

    // Input capture on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_r <= '0; vb_r <= '0; ia_r <= '0; ib_r <= '0;
            sin_r <= '0; cos_r <= '0;
        end else if (accept) begin
            va_r <= va_in; vb_r <= vb_in; ia_r <= ia_in; ib_r <= ib_in;
            sin_r <= sin_in; cos_r <= cos_in;
        end
    end

    clarke_park_seq #(.NSTEP(NUM_STEPS)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
        .busy(busy), .issue_valid(issue_valid), .step(step), .done(done)
    );

    clarke_park_opmux #(.SW(SW), .TW(TW), .COEF_K(COEF_K), .CW(CW)) i_opmux (
        .issue_valid(issue_valid), .step(step),
        .v_a(va_r), .v_b(vb_r), .i_a(ia_r), .i_b(ib_r),
        .sin_v(sin_r), .cos_v(cos_r), .beta(beta),
        .opa(opa), .opb(opb), .wb_op(wb_op), .set_sel(set_sel)
    );

    clarke_park_mac #(.SW(SW), .TW(TW), .OW(OW)) i_mac (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .opa(opa), .opb(opb), .wb_op(wb_op), .set_sel(set_sel),
        .beta(beta), .d_out(d_arr), .q_out(q_arr)
    );

    assign vd_out = d_arr[0];
    assign vq_out = q_arr[0];
    assign id_out = d_arr[1];
    assign iq_out = q_arr[1];

    AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(va_r) && $stable(ib_r) && $stable(sin_r) && $stable(cos_r))); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(vd_out) && $stable(vq_out) && $stable(id_out) && $stable(iq_out))); // R8
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (vd_out == 0 && iq_out == 0)); // R1

endmodule

// File: tb/test_clarke_park_tdm.sv
module test_clarke_park_tdm;

    localparam int LAT = 11;
    localparam longint K = 18919;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [11:0] va_in = '0, vb_in = '0, ia_in = '0, ib_in = '0;
    logic signed [15:0] sin_in = '0, cos_in = '0;
    logic signed [17:0] vd_out, vq_out, id_out, iq_out;
    logic done;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clarke_park_tdm i_clarke_park_tdm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .va_in(va_in), .vb_in(vb_in), .ia_in(ia_in), .ib_in(ib_in),
        .sin_in(sin_in), .cos_in(cos_in),
        .vd_out(vd_out), .vq_out(vq_out), .id_out(id_out), .iq_out(iq_out),
        .done(done)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Closed-form model from R2/R3
    function automatic longint m_d(longint a, longint b, longint s, longint k);
        longint beta = ((a + 2 * b) * K) >>> 15;
        return (a * k + beta * s) >>> 15;
    endfunction
    function automatic longint m_q(longint a, longint b, longint s, longint k);
        longint beta = ((a + 2 * b) * K) >>> 15;
        return (beta * k - a * s) >>> 15;
    endfunction

    // Drive a start with given inputs; returns after the accepting edge
    task automatic launch(input int va, input int vb, input int ia, input int ib,
                          input int s, input int k);
        va_in = 12'(va); vb_in = 12'(vb); ia_in = 12'(ia); ib_in = 12'(ib);
        sin_in = 16'(s); cos_in = 16'(k);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R5: disturb inputs right after capture
        va_in = 12'(-va); vb_in = 12'(ia); ia_in = 12'(vb); ib_in = 12'(7);
        sin_in = 16'(k); cos_in = 16'(-s);
    endtask

    // Wait for done, check latency; optional mid-run start (R7)
    task automatic wait_done(input string tag, input bit poke);
        int n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) start = 1'b1;
            if (poke && n == 4) start = 1'b0;
        end
        chk(n, LAT, {tag, " R6 latency"});
    endtask

    task automatic check_outs(input int va, input int vb, input int ia, input int ib,
                              input int s, input int k, input string tag);
        chk(vd_out, m_d(va, vb, s, k), {tag, " R2 R3 R4 vd"});
        chk(vq_out, m_q(va, vb, s, k), {tag, " R3 R4 vq"});
        chk(id_out, m_d(ia, ib, s, k), {tag, " R4 R5 id"});
        chk(iq_out, m_q(ia, ib, s, k), {tag, " R4 R5 iq"});
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(done, 0, "R1 done");
        chk(vd_out, 0, "R1 vd"); chk(vq_out, 0, "R1 vq");
        chk(id_out, 0, "R1 id"); chk(iq_out, 0, "R1 iq");
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_run(input int va, input int vb, input int ia, input int ib,
                         input int s, input int k, input string tag);
        launch(va, vb, ia, ib, s, k);
        wait_done(tag, 1'b0);
        check_outs(va, vb, ia, ib, s, k, tag);
        @(negedge clk);
        chk(done, 0, {tag, " R6 pulse width"});
    endtask

    task automatic t_busy_ignore();
        launch(1000, -300, 250, 600, 12000, 28000);
        wait_done("busy", 1'b1);
        check_outs(1000, -300, 250, 600, 12000, 28000, "busy R7");
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (done) chk(done, 0, "R7 extra done");
        end
        checks++;
        check_outs(1000, -300, 250, 600, 12000, 28000, "idle R8");
    endtask

    task automatic t_back_to_back();
        launch(-1500, 400, 900, -900, -20000, 15000);
        wait_done("b2b first", 1'b0);
        check_outs(-1500, 400, 900, -900, -20000, 15000, "b2b first");
        // R9: start in the done cycle
        launch(333, 777, -2048, 2047, 5000, -31000);
        wait_done("b2b R9", 1'b0);
        check_outs(333, 777, -2048, 2047, 5000, -31000, "b2b R9");
    endtask

    initial begin
        t_reset();
        t_run(1000, 0, 0, 1000, 0, 32767, "angle0");
        t_run(500, -250, -400, 800, 23170, 23170, "angle45");
        t_run(-2048, -2048, 2047, 2047, -32768, 0, "extreme");
        t_run(2047, -2048, -1, 1, 32767, -32768, "mixed");
        t_run(123, 456, -789, 321, -18000, -27000, "neg trig");
        t_busy_ignore();
        t_back_to_back();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R6 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule